// File: doc/BRIEF.md
# Commit-Point Interrupt Flush Controller

This controller lets an out-of-order core take asynchronous interrupts at the point where instructions retire, not at decode. It keeps a running copy of the architectural next PC, which is the address of the oldest instruction not yet committed. When a request is pending, it refuses further retirement at that boundary. It then issues a one-cycle flush that discards every younger in-flight operation, in the same way as a mispredicted branch. In that same cycle it presents the saved return address and a redirect of fetch to the configured handler entry. The handler's instructions therefore never wait behind slow older work, and its stores and I/O become visible as early as the machine allows.

The retire port is a simple single-slot in-order interface. The reorder buffer offers its head with `retValid` and supplies the PC that follows the head instruction in `retNextPc`. That value is the branch target when the head is a taken branch. The controller answers with `retCommit`. Interrupt requests arrive as one-cycle pulses on `irqReq`. Each pulse is counted, and each is answered by exactly one `irqAck` pulse.

Top module: `irq_commit_flush`

## Requirements
- R1: While reset is held and at its release, `flushOut`, `irqAck` and `redirValid` are 0, and `retAddr` and `redirPc` are 0.
- R2: While no interrupt is pending and none is being entered, `retCommit` equals `retValid`, and `retCommit` is never 1 while `retValid` is 0.
- R3: Once a request has been counted, `retCommit` stays 0 in the stop cycle and in the following entry cycle. An instruction that commits in the same cycle as the `irqReq` pulse still completes.
- R4: A request whose pulse is sampled at clock edge t, with nothing pending before it, makes `flushOut` 1 for exactly the one cycle that follows edge t+1.
- R5: `irqAck` is 1 in exactly the cycles in which `flushOut` is 1.
- R6: `redirValid` is 1 together with `flushOut`. `redirPc` then holds the value `handlerVec` had in the stop cycle.
- R7: From the flush cycle onward, `retAddr` holds the PC of the first uncommitted instruction. That is the `retNextPc` of the last committed instruction, or `RESET_PC` if nothing has committed since reset.
- R8: `retAddr` and `redirPc` change only at the edge that starts a flush cycle, and hold their values otherwise.
- R9: A request that arrives during a stop or entry cycle is kept pending. It is taken no earlier than the cycle after the entry cycle, and each counted request produces exactly one flush.
- R10: The pending count saturates at 2^PEND_W-1 (3 by default). Pulses beyond that are dropped and produce no flush.
- R11: `retNextPc` has no effect when `retValid` is 0 or when commit is being held off. It does not reach the next `retAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 1 | One-cycle pulse per interrupt request |
| handlerVec | input | PC_W | Handler entry address (configuration) |
| retValid | input | 1 | Reorder-buffer head is complete and may retire |
| retNextPc | input | PC_W | PC that follows the head instruction |
| retCommit | output | 1 | Head retires in this cycle |
| flushOut | output | 1 | One-cycle cancel of all in-flight work |
| irqAck | output | 1 | One-cycle acknowledge of the taken request |
| redirValid | output | 1 | Fetch redirect strobe |
| redirPc | output | PC_W | Fetch redirect target |
| retAddr | output | PC_W | Saved interrupt return address |

## Verification
The controller is driven in five ways: with a steady retire stream and no requests; with a single request whose pulse lands in the same cycle as a commit; with a request while the reorder buffer is empty and `retNextPc` carries junk; with requests that fall into a stop or entry cycle; and with a long run of back-to-back pulses. The first case separates correct pass-through from any spurious hold-off. The commit-coincident request shows whether the boundary is precise or off by one instruction. The empty-buffer case shows whether ignored retire data leaks into the return address. The overlapping and burst patterns separate correct queuing from lost or duplicated takes, and confirm that saturation drops pulses at the right count. A behavioural model, compared on every cycle, then covers a long random mix of all of these.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

  typedef enum logic [0:0] {
    ST_RUN   = 1'b0,
    ST_ENTRY = 1'b1
  } takeState_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // stop cycle: latch return address and handler target
    logic commitOk;  // head instruction retires this cycle
  } ctrlStb_t;

endpackage

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl
  import irq_take_pkg::*;
#(
  parameter int PEND_W = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     irqReq,
  input  logic     retValid,
  output ctrlStb_t stb
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  takeState_e      state, stateNext;
  logic [PEND_W-1:0] pendCnt, pendNext;
  logic            takeNow;
  logic            running;

  assign running = (state == ST_RUN);
  assign takeNow = running && (pendCnt != '0);

  always_comb begin
    stb.capture  = takeNow;
    stb.commitOk = retValid && running && (pendCnt == '0);
  end

  always_comb begin
    stateNext = takeNow ? ST_ENTRY : ST_RUN;
  end

  generate
    if (PEND_W == 1) begin : g_pendBit
      always_comb begin
        pendNext = (pendCnt & ~takeNow) | irqReq;
      end
    end else begin : g_pendCnt
      logic [PEND_W:0] pendSum;
      always_comb begin
        pendSum = {1'b0, pendCnt} - {{PEND_W{1'b0}}, takeNow} + {{PEND_W{1'b0}}, irqReq};
        if (pendSum > {1'b0, PEND_MAX}) pendNext = PEND_MAX;
        else                            pendNext = pendSum[PEND_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      pendCnt <= '0;
    end else begin
      state   <= stateNext;
      pendCnt <= pendNext;
    end
  end

endmodule

// File: rtl/irq_take_dpath.sv
module irq_take_dpath
  import irq_take_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStb_t        stb,
  input  logic [PC_W-1:0] retNextPc,
  input  logic [PC_W-1:0] handlerVec,
  output logic            flushOut,
  output logic            irqAck,
  output logic            redirValid,
  output logic [PC_W-1:0] redirPc,
  output logic [PC_W-1:0] retAddr
);

  logic [PC_W-1:0] archPc;

  // PC of the oldest uncommitted instruction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             archPc <= RESET_PC;
    else if (stb.commitOk) archPc <= retNextPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retAddr <= '0;
      redirPc <= '0;
    end else if (stb.capture) begin
      retAddr <= archPc;
      redirPc <= handlerVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushOut   <= 1'b0;
      irqAck     <= 1'b0;
      redirValid <= 1'b0;
    end else begin
      flushOut   <= stb.capture;
      irqAck     <= stb.capture;
      redirValid <= stb.capture;
    end
  end

endmodule

// File: rtl/irq_commit_flush.sv
module irq_commit_flush
  import irq_take_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              PEND_W   = 2,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic [PC_W-1:0] handlerVec,
  input  logic            retValid,
  input  logic [PC_W-1:0] retNextPc,
  output logic            retCommit,
  output logic            flushOut,
  output logic            irqAck,
  output logic            redirValid,
  output logic [PC_W-1:0] redirPc,
  output logic [PC_W-1:0] retAddr
);

  ctrlStb_t stb;

  irq_take_ctrl #(.PEND_W(PEND_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .retValid (retValid),
    .stb      (stb)
  );

  irq_take_dpath #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .retNextPc  (retNextPc),
    .handlerVec (handlerVec),
    .flushOut   (flushOut),
    .irqAck     (irqAck),
    .redirValid (redirValid),
    .redirPc    (redirPc),
    .retAddr    (retAddr)
  );

  assign retCommit = stb.commitOk;

endmodule

// File: rtl/irq_commit_flush_chk.sv
module irq_commit_flush_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] handlerVec,
  input logic            retValid,
  input logic            retCommit,
  input logic            flushOut,
  input logic            irqAck,
  input logic            redirValid,
  input logic [PC_W-1:0] redirPc,
  input logic [PC_W-1:0] retAddr
);

  p_commit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    retCommit |-> retValid);

  p_no_commit_in_flush_r3: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> !retCommit);

  p_flush_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut);

  p_ack_is_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqAck == flushOut);

  p_redir_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> (redirValid && redirPc == $past(handlerVec)));

  p_retaddr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !flushOut |-> ($stable(retAddr) && $stable(redirPc)));

endmodule

bind irq_commit_flush irq_commit_flush_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .handlerVec (handlerVec),
  .retValid   (retValid),
  .retCommit  (retCommit),
  .flushOut   (flushOut),
  .irqAck     (irqAck),
  .redirValid (redirValid),
  .redirPc    (redirPc),
  .retAddr    (retAddr)
);

// File: tb/irq_commit_flush_tb.sv
module irq_commit_flush_tb;

  localparam int          PC_W     = 32;
  localparam int          PEND_W   = 2;
  localparam logic [31:0] RESET_PC = 32'h0000_1000;
  localparam int          PEND_MAX = (1 << PEND_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0;
  logic [31:0] handlerVec = 32'h0000_8000;
  logic        retValid = 1'b0;
  logic [31:0] retNextPc = '0;
  logic        retCommit, flushOut, irqAck, redirValid;
  logic [31:0] redirPc, retAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int          mPend = 0;
  int          mPhase = 0;
  logic [31:0] mArch = RESET_PC;
  logic [31:0] mRetAddr = '0;
  logic [31:0] mRedir = '0;
  bit          mFlush = 0;
  int          mTakes = 0;
  int          dutFlushes = 0;
  bit          cmpOn = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_commit_flush #(.PC_W(PC_W), .PEND_W(PEND_W), .RESET_PC(RESET_PC)) u_dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .handlerVec(handlerVec),
    .retValid(retValid), .retNextPc(retNextPc), .retCommit(retCommit),
    .flushOut(flushOut), .irqAck(irqAck), .redirValid(redirValid),
    .redirPc(redirPc), .retAddr(retAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model, one step per clock
  always @(posedge clk) begin
    if (!rstN) begin
      mPend = 0; mPhase = 0; mArch = RESET_PC; mRetAddr = '0; mRedir = '0; mFlush = 0;
    end else begin
      bit stopNow, commitNow;
      stopNow   = (mPhase == 0) && (mPend > 0);
      commitNow = retValid && (mPhase == 0) && (mPend == 0);
      if (commitNow) mArch = retNextPc;
      if (stopNow) begin
        mRetAddr = mArch;
        mRedir   = handlerVec;
        mTakes++;
      end
      mFlush = stopNow;
      mPend  = mPend - (stopNow ? 1 : 0) + (irqReq ? 1 : 0);
      if (mPend > PEND_MAX) mPend = PEND_MAX;
      mPhase = stopNow ? 1 : 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      bit expCommit;
      expCommit = retValid && (mPhase == 0) && (mPend == 0);
      chk(expCommit ? "R2" : "R3", "retCommit", {31'b0, retCommit}, {31'b0, expCommit});
      chk("R4", "flushOut", {31'b0, flushOut}, {31'b0, mFlush});
      chk("R5", "irqAck", {31'b0, irqAck}, {31'b0, mFlush});
      chk("R6", "redirValid", {31'b0, redirValid}, {31'b0, mFlush});
      chk("R6", "redirPc", redirPc, mRedir);
      chk("R7", "retAddr", retAddr, mRetAddr);
      if (flushOut) dutFlushes++;
    end
  end

  task automatic step(input bit v, input logic [31:0] npc, input bit irq);
    @(posedge clk); #2;
    retValid = v; retNextPc = npc; irqReq = irq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'hDEAD_0000 + i, 1'b0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] pc;
    int base;
    pc = RESET_PC;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "flushOut in reset", {31'b0, flushOut}, 32'd0);
    chk("R1", "irqAck in reset", {31'b0, irqAck}, 32'd0);
    chk("R1", "redirValid in reset", {31'b0, redirValid}, 32'd0);
    chk("R1", "retAddr in reset", retAddr, 32'd0);
    chk("R1", "redirPc in reset", redirPc, 32'd0);
    rstN = 1'b1;
    cmpOn = 1;

    // R7: interrupt with nothing committed yet -> RESET_PC
    step(1'b0, 32'h1234_5678, 1'b1);
    idle(4);
    chk("R7", "retAddr before any commit", retAddr, RESET_PC);

    // R2: plain retire stream
    for (int i = 0; i < 10; i++) begin pc = pc + 4; step(1'b1, pc, 1'b0); end
    idle(2);

    // R3/R7: request pulse in the same cycle as a commit
    pc = 32'h0000_2000;
    step(1'b1, pc, 1'b0);
    pc = 32'h0000_2004;
    step(1'b1, pc, 1'b1);          // commits and is precise
    step(1'b1, 32'h0BAD_0001, 1'b0); // stop cycle: must not commit
    step(1'b1, 32'h0BAD_0002, 1'b0); // entry cycle: must not commit
    idle(1);
    chk("R7", "retAddr after same-cycle commit", retAddr, 32'h0000_2004);
    chk("R4", "one flush per request so far", dutFlushes, mTakes);

    // R11: junk retNextPc with retValid low, then take
    step(1'b0, 32'hFFFF_0000, 1'b0);
    step(1'b0, 32'hFFFF_1111, 1'b1);
    idle(4);
    chk("R11", "retAddr ignores junk", retAddr, 32'h0000_2004);

    // R8: long quiet retire without requests keeps retAddr
    for (int i = 0; i < 6; i++) begin pc = pc + 4; step(1'b1, pc, 1'b0); end
    idle(1);
    chk("R8", "retAddr held without flush", retAddr, 32'h0000_2004);

    // R6: new handler vector
    handlerVec = 32'h0000_C000;
    step(1'b0, 32'h0, 1'b1);
    idle(4);
    chk("R6", "redirPc follows handlerVec", redirPc, 32'h0000_C000);

    // R9: requests during stop and entry cycles
    base = mTakes;
    step(1'b1, pc + 4, 1'b1);
    step(1'b1, pc + 8, 1'b1);   // stop cycle
    step(1'b1, pc + 12, 1'b1);  // entry cycle
    idle(10);
    chk("R9", "three requests give three flushes", mTakes - base, 32'd3);
    chk("R9", "dut flush count", dutFlushes, mTakes);

    // R10: long burst saturates the pending count
    base = mTakes;
    for (int i = 0; i < 12; i++) step(1'b0, 32'h0, 1'b1);
    idle(20);
    chk("R10", "burst dropped pulses", (mTakes - base) < 12, 32'd1);
    chk("R10", "dut flush count after burst", dutFlushes, mTakes);

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[7:4] == 4'h0) handlerVec = {r[31:12], 12'h0};
      step(r[0] | r[1], {r[31:2], 2'b00}, r[11:8] == 4'h0);
    end
    idle(20);
    chk("R9", "flush count after random", dutFlushes, mTakes);

    finish_run();
  end

endmodule